// File: doc/BRIEF.md
# Serial Byte Transmitter

This block sends one byte at a time over an asynchronous serial line. While no frame is in flight the line rests high. A one-cycle start strobe presented while the block is idle does three things: it latches the byte, it latches the bit period, and it begins a frame. The frame is a low start bit, eight data bits sent least significant bit first, and a high stop bit. There is no parity bit.

The bit period is a run-time 16-bit value, counted in system clock cycles. For example, a value of 100 on a 100 MHz clock gives 1 Mbaud. A busy flag covers the whole frame. A one-cycle done pulse marks the end of the stop bit, and busy falls in that same cycle. The next byte may be strobed in the cycle where done is high. A strobe that arrives while busy is high is dropped.

Top module: `serial_byte_tx`

## Requirements
- R1: After a synchronous reset, and whenever busy is low, `line_o` is 1. Reset also clears `busy_o` and `done_o`.
- R2: If `start_i` is high at a clock edge where `busy_o` is low, `busy_o` is 1 and `line_o` is 0 (start bit) from the next cycle on.
- R3: Every bit of the frame holds `line_o` for exactly P cycles, where P is the latched period. A period value of 0 is treated as 1.
- R4: The frame on `line_o` is: start bit 0, then data bits 0 through 7 in that order (least significant first), then stop bit 1, with no parity. The frame lasts 10·P cycles.
- R5: In the cycle after the stop bit ends, `done_o` is 1 for exactly one cycle, `busy_o` is 0 and `line_o` stays 1.
- R6: A strobe at an edge where `busy_o` is high is ignored. The current frame is unchanged and no extra frame follows.
- R7: The byte is latched at frame start. Changes to `data_i` during the frame do not affect it.
- R8: The period is latched at frame start. Changes to `period_i` during the frame do not affect it.
- R9: A strobe in the cycle where `done_o` is high starts the next frame at once, with no idle cycle between frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle strobe that starts a frame |
| data_i | input | 8 | Byte to send |
| period_i | input | 16 | Bit period in clock cycles |
| line_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | High while a frame is in flight |
| done_o | output | 1 | One-cycle pulse at the end of the frame |

## Verification
The hardest case to reach from the ports is the boundary between frames. A strobe has to land exactly in the one cycle where done is high and busy has just dropped, and the bench must then show that the new start bit follows with no gap. The driver reaches this by polling for done at the falling edge and raising the strobe in that same cycle. A second hard case is a strobe that lands mid-frame. That strobe is issued a fixed number of cycles into a frame, with a different byte. The bench then confirms that the waveform is unchanged and that no second frame appears.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/sbt_bit_timer.sv
module sbt_bit_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic                run_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                bit_end_o
);
  logic [PERIOD_W-1:0] per_q;
  logic [PERIOD_W-1:0] cnt_q;

  // last count value of one bit; zero period behaves as one cycle
  function automatic logic [PERIOD_W-1:0] last_count(input logic [PERIOD_W-1:0] p);
    return (p == '0) ? '0 : p - PERIOD_W'(1);
  endfunction

  assign bit_end_o = run_i && (cnt_q == last_count(per_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      per_q <= period_i;
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= bit_end_o ? '0 : cnt_q + PERIOD_W'(1);
    end
  end
endmodule

// File: rtl/sbt_shifter.sv
module sbt_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              lsb_o
);
  logic [DATA_W-1:0] sh_q;

  assign lsb_o = sh_q[0];

  always_ff @(posedge clk) begin
    if (rst)          sh_q <= '0;
    else if (load_i)  sh_q <= data_i;
    else if (shift_i) sh_q <= {1'b0, sh_q[DATA_W-1:1]};
  end
endmodule

// File: rtl/sbt_fsm.sv
module sbt_fsm
  import sbt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic bit_end_i,
  input  logic lsb_i,
  output logic accept_o,
  output logic shift_o,
  output logic frame_end_o,
  output logic busy_o,
  output logic done_o,
  output logic line_o
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  tx_state_e        state_q;
  logic [IDX_W-1:0] idx_q;

  assign busy_o      = (state_q != ST_IDLE);
  assign accept_o    = start_i && (state_q == ST_IDLE);
  assign shift_o     = bit_end_i && ((state_q == ST_START) || (state_q == ST_DATA));
  assign frame_end_o = bit_end_i && (state_q == ST_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      line_o  <= 1'b1;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept_o) begin
            state_q <= ST_START;
            line_o  <= 1'b0;
          end
        end
        ST_START: begin
          if (bit_end_i) begin
            state_q <= ST_DATA;
            idx_q   <= '0;
            line_o  <= lsb_i;
          end
        end
        ST_DATA: begin
          if (bit_end_i) begin
            if (idx_q == LAST_IDX) begin
              state_q <= ST_STOP;
              line_o  <= 1'b1;
            end else begin
              idx_q  <= idx_q + IDX_W'(1);
              line_o <= lsb_i;
            end
          end
        end
        ST_STOP: begin
          if (bit_end_i) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_byte_tx.sv
module serial_byte_tx #(
  parameter int DATA_W   = 8,
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                line_o,
  output logic                busy_o,
  output logic                done_o
);
  logic accept;
  logic bit_end;
  logic shift;
  logic frame_end;
  logic lsb;

  sbt_bit_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (accept),
    .run_i     (busy_o),
    .period_i  (period_i),
    .bit_end_o (bit_end)
  );

  sbt_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load_i  (accept),
    .shift_i (shift),
    .data_i  (data_i),
    .lsb_o   (lsb)
  );

  sbt_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .bit_end_i   (bit_end),
    .lsb_i       (lsb),
    .accept_o    (accept),
    .shift_o     (shift),
    .frame_end_o (frame_end),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .line_o      (line_o)
  );
endmodule

// File: rtl/sbt_checker.sv
module sbt_checker #(
  parameter int DATA_W = 8
) (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic line_o,
  input logic busy_o,
  input logic done_o,
  input logic accept,
  input logic bit_end,
  input logic frame_end
);
  localparam int CW = $clog2(DATA_W + 2) + 1;
  logic [CW-1:0] bits_seen;

  always_ff @(posedge clk) begin
    if (rst || accept) bits_seen <= '0;
    else if (bit_end)  bits_seen <= bits_seen + CW'(1);
  end

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (line_o && !busy_o && !done_o));
  // R1
  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> line_o);
  // R2
  a_r2_start_bit: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (busy_o && !line_o));
  // R3
  a_r3_hold_bit: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !bit_end) |=> $stable(line_o));
  // R4
  a_r4_bit_count: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> (bits_seen == CW'(DATA_W + 1)));
  // R5
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R5
  a_r5_done_busy_drop: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o) && line_o));
  // R6
  a_r6_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !frame_end) |=> busy_o);
endmodule

bind serial_byte_tx sbt_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .line_o    (line_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .accept    (accept),
  .bit_end   (bit_end),
  .frame_end (frame_end)
);

// File: tb/serial_byte_tx_bench.sv
`timescale 1ns/1ps
module serial_byte_tx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [7:0]  data_i = 8'h00;
  logic [15:0] period_i = 16'd0;
  logic        line_o, busy_o, done_o;

  always #5 clk = ~clk;

  serial_byte_tx u_serial_byte_tx (
    .clk(clk), .rst(rst), .start_i(start_i), .data_i(data_i),
    .period_i(period_i), .line_o(line_o), .busy_o(busy_o), .done_o(done_o)
  );

  typedef struct {
    logic [7:0] b;
    int         p;
    string      tag;
  } exp_t;
  exp_t q[$];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic int eff(int p);
    return (p == 0) ? 1 : p;
  endfunction

  // bit k of frame: 0 start, 1..8 data LSB first, 9 stop
  function automatic logic bit_at(logic [7:0] b, int k);
    if (k == 0) return 1'b0;
    if (k <= 8) return b[k-1];
    return 1'b1;
  endfunction

  task automatic send(logic [7:0] b, int p, string tag, bit at_done);
    exp_t e;
    if (at_done) begin
      do @(negedge clk); while (!done_o);
    end else begin
      do @(negedge clk); while (busy_o);
    end
    data_i   = b;
    period_i = 16'(p);
    start_i  = 1'b1;
    e.b = b; e.p = p; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    #1;
    start_i  = 1'b0;
    data_i   = ~b;             // R7: changed byte must not matter
    period_i = 16'(p + 7);     // R8: changed period must not matter
    @(negedge clk);
    check(busy_o === 1'b1 && line_o === 1'b0, at_done ? "R9" : "R2",
          "start bit after strobe", {busy_o, line_o}, 2'b10);
  endtask

  // scoreboard monitor
  initial begin
    bit after_done = 0;
    forever begin
      @(negedge clk);
      if (after_done) begin
        check(done_o === 1'b0, "R5", "done lasts one cycle", done_o, 0);
        after_done = 0;
      end
      if (!rst && busy_o) begin
        if (q.size() == 0) begin
          check(1'b0, "R6", "unexpected frame", 1, 0);
          while (busy_o) @(negedge clk);
        end else begin
          exp_t e;
          int   pp;
          int   bad;
          int   act_v;
          int   exp_v;
          e = q.pop_front();
          pp = eff(e.p);
          bad = 0; act_v = 0; exp_v = 0;
          for (int c = 0; c < 10 * pp; c++) begin
            if (c > 0) @(negedge clk);
            if (line_o !== bit_at(e.b, c / pp) || busy_o !== 1'b1 || done_o !== 1'b0) begin
              if (bad == 0) begin
                act_v = {c, 1'b0, busy_o, done_o, line_o};
                exp_v = {c, 1'b0, 1'b1, 1'b0, bit_at(e.b, c / pp)};
              end
              bad++;
            end
          end
          check(bad == 0, e.tag, "frame waveform (R3 R4)", act_v, exp_v);
          @(negedge clk);
          check(done_o === 1'b1 && busy_o === 1'b0 && line_o === 1'b1, "R5",
                "end of frame flags", {done_o, busy_o, line_o}, 3'b101);
          after_done = 1;
        end
      end
    end
  end

  // watchdog
  initial begin
    #1500000;
    if (!finished) begin
      check(1'b0, "watchdog", "run timed out", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(line_o === 1'b1 && busy_o === 1'b0 && done_o === 1'b0, "R1",
          "reset state", {line_o, busy_o, done_o}, 3'b100);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(line_o === 1'b1 && busy_o === 1'b0, "R1", "idle after reset",
          {line_o, busy_o}, 2'b10);

    send(8'hD5, 4,   "R4 lsb-first",          0);
    send(8'h00, 1,   "R3 one-cycle bits",     0);
    send(8'hFF, 3,   "R4 all ones",           0);
    send(8'hA6, 0,   "R3 zero period",        0);
    send(8'h5A, 100, "R3 1 Mbaud",            0);
    send(8'h3C, 5,   "R7 R8 latched inputs",  0);

    // R6: strobe mid-frame with another byte
    send(8'h81, 6, "R6 strobe while busy", 0);
    repeat (8) @(negedge clk);
    data_i = 8'h7E; period_i = 16'd2; start_i = 1'b1;
    @(posedge clk);
    #1 start_i = 1'b0;
    do @(negedge clk); while (busy_o);
    repeat (20) @(negedge clk);
    check(busy_o === 1'b0 && line_o === 1'b1 && q.size() == 0, "R6",
          "no extra frame", {busy_o, line_o}, 2'b01);

    // R9: back-to-back
    send(8'hC3, 2, "R4 before back-to-back", 0);
    send(8'h96, 2, "R9 back-to-back",        1);

    do @(negedge clk); while (busy_o || q.size() != 0);
    repeat (4) @(negedge clk);
    check(line_o === 1'b1, "R1", "final idle line", line_o, 1);
    finish_run();
  end
endmodule